// File: doc/BRIEF.md
# Byte-Accessed 16-bit Timer with Shared High-Byte Latch

This block is a free-running 16-bit up-counter whose four 16-bit registers (the count, two compare values and a capture value) are reached from an 8-bit register bus. Each 16-bit register has one address for its low byte and one for its high byte. The timer owns a single 8-bit holding latch, shared by all four registers. The latch lets software move a full 16-bit value in two byte accesses while the counter keeps advancing, without tearing the value.

To read, software reads the low byte first. That read returns the live low byte and, in the same clock edge, copies the matching high byte into the shared latch. A later high-byte read returns the latch, so both halves come from one count value. To write, software writes the high byte first, which only fills the latch. The low-byte write then loads latch and new low byte together into the 16-bit register. Because there is only one latch, a high-byte read returns whatever was last placed there, even if that was another register's high byte. The counter wraps to zero after it equals compare A and raises a sticky match flag. Compare B raises its own flag without reloading. A rising edge on the capture input stores the running count.

Top module: `tmr16_byte_timer`

## Requirements
- R1: After reset the count, both compare values, the capture value, the latch, both flags and the run bit are zero, so every address reads 0x00.
- R2: A read of a low-byte address (0x0 count, 0x2 compare A, 0x4 compare B, 0x6 capture) returns that register's live low byte on `bus_rdata_o` in the same cycle. At that clock edge it copies the register's high byte into the shared latch.
- R3: A read of any high-byte address (0x1, 0x3, 0x5, 0x7) returns the latch, not the live high byte. Repeated high-byte reads with no low-byte read between them return the same value while the counter advances.
- R4: A write to a high-byte address stores the byte in the latch only. A write to the low-byte address of the count, compare A or compare B loads {latch, written byte} into that 16-bit register at one clock edge.
- R5: The latch is common to all four registers. A low-byte read or a high-byte write of one register overwrites what an earlier access to another register left there. A high-byte write takes precedence over a low-byte read in the same cycle.
- R6: Bit 0 of the control register at address 0x9 is the run bit, readable at that address. While it is 1 the count goes up by one every cycle. While it is 0 the count holds. A bus write to the count's low byte overrides the step in that cycle.
- R7: When the run bit is 1 and the count equals compare A, the next edge loads the count with zero and sets match flag A. The flag shows on `match_a_irq_o` and in status bit 0 at address 0x8.
- R8: When the run bit is 1 and the count equals compare B, the next edge sets match flag B (`match_b_irq_o`, status bit 1) and the count still steps by one.
- R9: The flags are sticky. Writing a 1 to a status bit at 0x8 clears that flag. A match in the same cycle wins over the clear.
- R10: A rising edge on `capture_i`, after a two-stage synchronizer, loads the current count into the capture register. A bus write to the capture low byte (0x6) leaves the capture value unchanged.
- R11: `bus_rdata_o` is 0x00 whenever `bus_rd_i` is low, and for unmapped addresses 0xA to 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W (4) | Register byte address |
| bus_rd_i | input | 1 | Read strobe, one access per cycle it is high |
| bus_wr_i | input | 1 | Write strobe, one access per cycle it is high |
| bus_wdata_i | input | BYTE_W (8) | Write data byte |
| bus_rdata_o | output | BYTE_W (8) | Read data, valid in the cycle of the read strobe |
| capture_i | input | 1 | Asynchronous capture trigger, rising edge |
| match_a_irq_o | output | 1 | Sticky compare-A match flag |
| match_b_irq_o | output | 1 | Sticky compare-B match flag |

## Verification
The bench reads a high byte after the counter has crossed a 256 boundary. A design that returned the live high byte would show the new value instead of the snapshot. It reads high bytes after a low-byte read of a different register, so a design with one latch per register would fail to show the cross-register overwrite. It writes the count while running, which catches a design that lets the step win over the bus write. It issues a status clear in the same cycle as a compare-A match, which catches a design where the clear wins and the event is lost. It writes the capture low byte to confirm the capture register is read-only. It also steps through the cycles around the compare-A reload and the compare-B match, so an off-by-one reload or a compare B that reloads shows up in the literal count values.

// File: rtl/tmr16_pkg.sv
`timescale 1ns/1ps
package tmr16_pkg;

    // Byte address map: pairs occupy 0..7, low byte at even, high at odd
    localparam int unsigned NUM_PAIRS   = 4;
    localparam int unsigned PAIR_SPAN   = 2 * NUM_PAIRS;
    localparam int unsigned ADR_STATUS  = 8;
    localparam int unsigned ADR_CONTROL = 9;

    // Status bit positions
    localparam int unsigned STAT_A_BIT  = 0;
    localparam int unsigned STAT_B_BIT  = 1;
    localparam int unsigned CTRL_RUN_BIT = 0;

    typedef enum logic [1:0] {
        PAIR_COUNT = 2'd0,
        PAIR_CMP_A = 2'd1,
        PAIR_CMP_B = 2'd2,
        PAIR_CAPT  = 2'd3
    } tmr_pair_e;

    typedef struct packed {
        logic      pair_hit;
        logic      hi_half;
        tmr_pair_e pair;
        logic      stat_hit;
        logic      ctrl_hit;
    } tmr_dec_t;

endpackage

// File: rtl/tmr16_decode.sv
`timescale 1ns/1ps
module tmr16_decode
    import tmr16_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    output tmr_dec_t          dec_o
);

    localparam logic [ADDR_W-1:0] PAIR_LIMIT = ADDR_W'(PAIR_SPAN);
    localparam logic [ADDR_W-1:0] STAT_ADR   = ADDR_W'(ADR_STATUS);
    localparam logic [ADDR_W-1:0] CTRL_ADR   = ADDR_W'(ADR_CONTROL);

    always_comb begin
        dec_o          = '0;
        dec_o.pair_hit = (addr_i < PAIR_LIMIT);
        dec_o.hi_half  = addr_i[0];
        dec_o.pair     = tmr_pair_e'(addr_i[2:1]);
        dec_o.stat_hit = (addr_i == STAT_ADR);
        dec_o.ctrl_hit = (addr_i == CTRL_ADR);
    end

endmodule

// File: rtl/tmr16_edge_sync.sv
`timescale 1ns/1ps
module tmr16_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);

    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    always_comb begin
        sync_d[0] = async_i;
        prev_d    = sync_q[STAGES-1];
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_chain
        always_comb sync_d[s] = sync_q[s-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/tmr16_regs.sv
`timescale 1ns/1ps
module tmr16_regs
    import tmr16_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                rd_i,
    input  logic                wr_i,
    input  tmr_dec_t            dec_i,
    input  logic [BYTE_W-1:0]   wdata_i,
    input  logic                capt_pulse_i,
    output logic [BYTE_W-1:0]   rdata_o,
    output logic                flag_a_o,
    output logic                flag_b_o,
    output logic [2*BYTE_W-1:0] count_o,
    output logic [2*BYTE_W-1:0] cmp_a_o,
    output logic [BYTE_W-1:0]   latch_o,
    output logic                run_o
);

    localparam int unsigned REG_W = 2 * BYTE_W;

    typedef struct packed {
        logic [REG_W-1:0]  count;
        logic [REG_W-1:0]  cmp_a;
        logic [REG_W-1:0]  cmp_b;
        logic [REG_W-1:0]  capt;
        logic [BYTE_W-1:0] latch;
        logic              flag_a;
        logic              flag_b;
        logic              run;
    } tmr_state_t;

    tmr_state_t        st_d, st_q;
    logic [REG_W-1:0]  pair_val [NUM_PAIRS];
    logic              hit_a, hit_b;
    logic              rd_lo, wr_lo, wr_hi;
    logic              clr_a, clr_b;

    always_comb begin
        st_d = st_q;

        // Register values as seen by the pair index
        pair_val[PAIR_COUNT] = st_q.count;
        pair_val[PAIR_CMP_A] = st_q.cmp_a;
        pair_val[PAIR_CMP_B] = st_q.cmp_b;
        pair_val[PAIR_CAPT]  = st_q.capt;

        rd_lo = rd_i && dec_i.pair_hit && !dec_i.hi_half;
        wr_lo = wr_i && dec_i.pair_hit && !dec_i.hi_half;
        wr_hi = wr_i && dec_i.pair_hit &&  dec_i.hi_half;

        // Compare events only count while running
        hit_a = st_q.run && (st_q.count == st_q.cmp_a);
        hit_b = st_q.run && (st_q.count == st_q.cmp_b);

        if (st_q.run) begin
            st_d.count = hit_a ? '0 : st_q.count + 1'b1;
        end

        if (capt_pulse_i) begin
            st_d.capt = st_q.count;
        end

        // Shared latch: low read snapshots, high write loads (write wins)
        if (rd_lo) begin
            st_d.latch = pair_val[dec_i.pair][REG_W-1:BYTE_W];
        end
        if (wr_hi) begin
            st_d.latch = wdata_i;
        end

        // Low write commits latch plus byte; capture stays read-only
        if (wr_lo) begin
            unique case (dec_i.pair)
                PAIR_COUNT: st_d.count = {st_q.latch, wdata_i};
                PAIR_CMP_A: st_d.cmp_a = {st_q.latch, wdata_i};
                PAIR_CMP_B: st_d.cmp_b = {st_q.latch, wdata_i};
                default:    ;
            endcase
        end

        clr_a = wr_i && dec_i.stat_hit && wdata_i[STAT_A_BIT];
        clr_b = wr_i && dec_i.stat_hit && wdata_i[STAT_B_BIT];
        st_d.flag_a = (st_q.flag_a && !clr_a) || hit_a;
        st_d.flag_b = (st_q.flag_b && !clr_b) || hit_b;

        if (wr_i && dec_i.ctrl_hit) begin
            st_d.run = wdata_i[CTRL_RUN_BIT];
        end

        // Read data path, zero when idle
        rdata_o = '0;
        if (rd_i) begin
            if (dec_i.pair_hit) begin
                rdata_o = dec_i.hi_half ? st_q.latch
                                        : pair_val[dec_i.pair][BYTE_W-1:0];
            end else if (dec_i.stat_hit) begin
                rdata_o[STAT_A_BIT] = st_q.flag_a;
                rdata_o[STAT_B_BIT] = st_q.flag_b;
            end else if (dec_i.ctrl_hit) begin
                rdata_o[CTRL_RUN_BIT] = st_q.run;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_a_o = st_q.flag_a;
    assign flag_b_o = st_q.flag_b;
    assign count_o  = st_q.count;
    assign cmp_a_o  = st_q.cmp_a;
    assign latch_o  = st_q.latch;
    assign run_o    = st_q.run;

endmodule

// File: rtl/tmr16_byte_timer.sv
`timescale 1ns/1ps
module tmr16_byte_timer
    import tmr16_pkg::*;
#(
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic [BYTE_W-1:0] bus_wdata_i,
    output logic [BYTE_W-1:0] bus_rdata_o,
    input  logic              capture_i,
    output logic              match_a_irq_o,
    output logic              match_b_irq_o
);

    localparam int unsigned REG_W = 2 * BYTE_W;

    tmr_dec_t          dec;
    logic              capt_pulse;
    logic [REG_W-1:0]  count_w;
    logic [REG_W-1:0]  cmp_a_w;
    logic [BYTE_W-1:0] latch_w;
    logic              run_w;

    tmr16_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr_i (bus_addr_i),
        .dec_o  (dec)
    );

    tmr16_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_capt_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (capture_i),
        .rise_o  (capt_pulse)
    );

    tmr16_regs #(
        .BYTE_W (BYTE_W)
    ) u_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .rd_i         (bus_rd_i),
        .wr_i         (bus_wr_i),
        .dec_i        (dec),
        .wdata_i      (bus_wdata_i),
        .capt_pulse_i (capt_pulse),
        .rdata_o      (bus_rdata_o),
        .flag_a_o     (match_a_irq_o),
        .flag_b_o     (match_b_irq_o),
        .count_o      (count_w),
        .cmp_a_o      (cmp_a_w),
        .latch_o      (latch_w),
        .run_o        (run_w)
    );

endmodule

// File: rtl/tmr16_byte_timer_chk.sv
`timescale 1ns/1ps
module tmr16_byte_timer_chk #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd,
    input logic              wr,
    input logic [BYTE_W-1:0] wdata,
    input logic [BYTE_W-1:0] rdata,
    input logic              flag_a,
    input logic              flag_b,
    input logic [2*BYTE_W-1:0] count,
    input logic [2*BYTE_W-1:0] cmp_a,
    input logic [BYTE_W-1:0] latch,
    input logic              run
);

    localparam int unsigned REG_W = 2 * BYTE_W;

    logic in_pairs, cnt_lo_wr, cnt_lo_rd, any_lo_rd, any_hi_wr, any_hi_rd, clr_a_wr;

    always_comb begin
        in_pairs  = (addr < ADDR_W'(8));
        any_lo_rd = rd && in_pairs && !addr[0];
        any_hi_rd = rd && in_pairs &&  addr[0];
        any_hi_wr = wr && in_pairs &&  addr[0];
        cnt_lo_wr = wr && (addr == ADDR_W'(0));
        cnt_lo_rd = rd && (addr == ADDR_W'(0));
        clr_a_wr  = wr && (addr == ADDR_W'(8)) && wdata[0];
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_state_R1: assert (count == '0 && latch == '0 &&
                                          !flag_a && !flag_b && !run)
                else $error("reset state wrong");
        end
    end

    assert_lo_snapshot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_lo_rd && !wr) |=> (latch == $past(count[REG_W-1:BYTE_W])));

    assert_hi_from_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        any_hi_rd |-> (rdata == latch));

    assert_lo_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_lo_wr |=> (count == {$past(latch), $past(wdata)}));

    assert_latch_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_lo_rd && !any_hi_wr) |=> $stable(latch));

    assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_lo_wr) |=> $stable(count));

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (count != cmp_a) && !cnt_lo_wr) |=> (count == REG_W'($past(count) + 1'b1)));

    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (count == cmp_a) && !cnt_lo_wr) |=> (count == '0 && flag_a));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_a && !clr_a_wr) |=> flag_a);

endmodule

bind tmr16_byte_timer tmr16_byte_timer_chk #(
    .BYTE_W (BYTE_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk    (clk_i),
    .rst_n  (rst_ni),
    .addr   (bus_addr_i),
    .rd     (bus_rd_i),
    .wr     (bus_wr_i),
    .wdata  (bus_wdata_i),
    .rdata  (bus_rdata_o),
    .flag_a (match_a_irq_o),
    .flag_b (match_b_irq_o),
    .count  (count_w),
    .cmp_a  (cmp_a_w),
    .latch  (latch_w),
    .run    (run_w)
);

// File: tb/tmr16_byte_timer_test.sv
`timescale 1ns/1ps
module tmr16_byte_timer_test;

    localparam logic [3:0] A_CNT_LO = 4'h0, A_CNT_HI = 4'h1;
    localparam logic [3:0] A_CA_LO  = 4'h2, A_CA_HI  = 4'h3;
    localparam logic [3:0] A_CB_LO  = 4'h4, A_CB_HI  = 4'h5;
    localparam logic [3:0] A_CP_LO  = 4'h6, A_CP_HI  = 4'h7;
    localparam logic [3:0] A_STAT   = 4'h8, A_CTRL   = 4'h9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       capture = 1'b0;
    logic       irq_a, irq_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    tmr16_byte_timer uut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .bus_addr_i    (bus_addr),
        .bus_rd_i      (bus_rd),
        .bus_wr_i      (bus_wr),
        .bus_wdata_i   (bus_wdata),
        .bus_rdata_o   (bus_rdata),
        .capture_i     (capture),
        .match_a_irq_o (irq_a),
        .match_b_irq_o (irq_b)
    );

    // Reference model built from the requirements
    logic [15:0] m_cnt, m_ca, m_cb, exp_cap;
    logic [7:0]  m_latch;
    logic        m_fa, m_fb, m_run;

    function automatic logic [15:0] m_pair(input logic [1:0] s);
        case (s)
            2'd0:    return m_cnt;
            2'd1:    return m_ca;
            2'd2:    return m_cb;
            default: return exp_cap;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        if (a < 4'h8) return a[0] ? m_latch : m_pair(a[2:1])[7:0];
        if (a == A_STAT) return {6'b0, m_fb, m_fa};
        if (a == A_CTRL) return {7'b0, m_run};
        return 8'h00;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        logic ma, mb;
        if (!rst_n) begin
            m_cnt <= '0; m_ca <= '0; m_cb <= '0; m_latch <= '0;
            m_fa <= 1'b0; m_fb <= 1'b0; m_run <= 1'b0;
        end else begin
            ma = m_run && (m_cnt == m_ca);
            mb = m_run && (m_cnt == m_cb);
            if (m_run) m_cnt <= ma ? 16'h0 : m_cnt + 16'h1;
            if (bus_rd && bus_addr < 4'h8 && !bus_addr[0]) m_latch <= m_pair(bus_addr[2:1])[15:8];
            if (bus_wr && bus_addr < 4'h8 &&  bus_addr[0]) m_latch <= bus_wdata;
            if (bus_wr) begin
                case (bus_addr)
                    A_CNT_LO: m_cnt <= {m_latch, bus_wdata};
                    A_CA_LO:  m_ca  <= {m_latch, bus_wdata};
                    A_CB_LO:  m_cb  <= {m_latch, bus_wdata};
                    A_CTRL:   m_run <= bus_wdata[0];
                    default:  ;
                endcase
            end
            m_fa <= (m_fa && !(bus_wr && bus_addr == A_STAT && bus_wdata[0])) || ma;
            m_fb <= (m_fb && !(bus_wr && bus_addr == A_STAT && bus_wdata[1])) || mb;
        end
    end

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic op_idle();
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic op_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic op_read(input logic [3:0] a, input string tag, output logic [7:0] got);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
        #1;
        got = bus_rdata;
        check(tag, {8'h0, got}, {8'h0, exp_read(a)});
    endtask

    task automatic rd_lit(input logic [3:0] a, input string tag, input logic [7:0] lit);
        logic [7:0] v;
        op_read(a, tag, v);
        check(tag, {8'h0, v}, {8'h0, lit});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        exp_cap = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: everything reads zero after reset
        for (int a = 0; a < 10; a++) rd_lit(4'(a), "R1", 8'h00);
        op_idle(); #1;
        check("R1", {14'h0, irq_b, irq_a}, 16'h0);
        // R11: idle bus reads zero, unmapped reads zero
        check("R11", {8'h0, bus_rdata}, 16'h0);
        rd_lit(4'hC, "R11", 8'h00);

        // R4: two-step writes commit both bytes
        op_write(A_CNT_HI, 8'h00); op_write(A_CNT_LO, 8'hF0);
        op_write(A_CA_HI, 8'h23);  op_write(A_CA_LO, 8'h28);
        op_write(A_CB_HI, 8'hFF);  op_write(A_CB_LO, 8'hFF);
        rd_lit(A_CA_LO, "R4", 8'h28);
        rd_lit(A_CA_HI, "R4", 8'h23);
        op_write(A_CTRL, 8'h01);
        rd_lit(A_CTRL, "R6", 8'h00 | 8'h01);

        // R2/R3: snapshot stays while counting past 0x100
        rd_lit(A_CNT_LO, "R2", 8'hF1);
        repeat (40) op_idle();
        rd_lit(A_CNT_HI, "R3", 8'h00);
        rd_lit(A_CNT_HI, "R3", 8'h00);
        begin
            logic [7:0] v;
            op_read(A_CNT_LO, "R2", v);
        end
        rd_lit(A_CNT_HI, "R3", 8'h01);

        // R5: shared latch gets overwritten by another register
        begin
            logic [7:0] v;
            op_read(A_CNT_LO, "R2", v);
        end
        rd_lit(A_CA_LO, "R5", 8'h28);
        rd_lit(A_CNT_HI, "R5", 8'h23);
        op_write(A_CTRL, 8'h00);
        op_write(A_CNT_HI, 8'h05);
        rd_lit(A_CB_LO, "R5", 8'hFF);
        op_write(A_CNT_LO, 8'h00);
        rd_lit(A_CNT_LO, "R5", 8'h00);
        rd_lit(A_CNT_HI, "R5", 8'hFF);

        // R6: hold while stopped, bus write beats the step
        repeat (5) op_idle();
        rd_lit(A_CNT_LO, "R6", 8'h00);
        rd_lit(A_CNT_HI, "R6", 8'hFF);
        op_write(A_CTRL, 8'h01);
        op_write(A_CNT_HI, 8'h00);
        op_write(A_CNT_LO, 8'h40);
        rd_lit(A_CNT_LO, "R6", 8'h40);
        rd_lit(A_CNT_LO, "R6", 8'h41);

        // R7: reload after equality with compare A
        op_write(A_CTRL, 8'h00);
        op_write(A_CA_HI, 8'h00); op_write(A_CA_LO, 8'h10);
        op_write(A_CNT_HI, 8'h00); op_write(A_CNT_LO, 8'h0D);
        op_write(A_STAT, 8'h03);
        op_write(A_CTRL, 8'h01);
        rd_lit(A_CNT_LO, "R7", 8'h0D);
        rd_lit(A_CNT_LO, "R7", 8'h0E);
        rd_lit(A_CNT_LO, "R7", 8'h0F);
        rd_lit(A_CNT_LO, "R7", 8'h10);
        check("R7", {15'h0, irq_a}, 16'h0);
        rd_lit(A_CNT_LO, "R7", 8'h00);
        check("R7", {15'h0, irq_a}, 16'h1);
        rd_lit(A_STAT, "R7", 8'h01);

        // R8: compare B flags without reload
        op_write(A_CTRL, 8'h00);
        op_write(A_CA_HI, 8'hFF); op_write(A_CA_LO, 8'hFF);
        op_write(A_CB_HI, 8'h00); op_write(A_CB_LO, 8'h05);
        op_write(A_CNT_HI, 8'h00); op_write(A_CNT_LO, 8'h03);
        op_write(A_STAT, 8'h03);
        op_write(A_CTRL, 8'h01);
        rd_lit(A_CNT_LO, "R8", 8'h03);
        rd_lit(A_CNT_LO, "R8", 8'h04);
        rd_lit(A_CNT_LO, "R8", 8'h05);
        check("R8", {15'h0, irq_b}, 16'h0);
        rd_lit(A_CNT_LO, "R8", 8'h06);
        check("R8", {15'h0, irq_b}, 16'h1);
        rd_lit(A_STAT, "R8", 8'h02);

        // R9: write-one clear, and match wins over clear
        op_write(A_CTRL, 8'h00);
        op_write(A_STAT, 8'h02);
        op_idle(); #1;
        check("R9", {14'h0, irq_b, irq_a}, 16'h0);
        op_write(A_CA_HI, 8'h00); op_write(A_CA_LO, 8'h20);
        op_write(A_CNT_HI, 8'h00); op_write(A_CNT_LO, 8'h20);
        op_write(A_CTRL, 8'h01);
        op_write(A_STAT, 8'h01);
        op_idle(); #1;
        check("R9", {15'h0, irq_a}, 16'h1);
        op_write(A_STAT, 8'h01);
        op_idle(); #1;
        check("R9", {15'h0, irq_a}, 16'h0);

        // R10: capture a stopped count, capture is read-only
        op_write(A_CTRL, 8'h00);
        op_write(A_CNT_HI, 8'h12); op_write(A_CNT_LO, 8'h34);
        op_idle();
        exp_cap = 16'h1234;
        capture = 1'b1;
        repeat (4) op_idle();
        capture = 1'b0;
        repeat (4) op_idle();
        rd_lit(A_CP_LO, "R10", 8'h34);
        rd_lit(A_CP_HI, "R10", 8'h12);
        op_write(A_CP_LO, 8'h99);
        rd_lit(A_CP_LO, "R10", 8'h34);

        // Constrained random traffic against the model
        begin
            process::self().srandom(32'h5EED_1234);
            for (int i = 0; i < 4000; i++) begin
                int unsigned kind = $urandom_range(0, 9);
                logic [3:0] a = 4'($urandom_range(0, 11));
                logic [7:0] d = 8'($urandom);
                logic [7:0] v;
                if (kind < 3) begin
                    if (a == A_CTRL) d[0] = 1'b1;
                    op_write(a, d);
                end else if (kind < 8) begin
                    if (a < 4'h8) op_read(a, a[0] ? "R3" : "R2", v);
                    else if (a == A_STAT) op_read(a, "R9", v);
                    else if (a == A_CTRL) op_read(a, "R6", v);
                    else op_read(a, "R11", v);
                    check("R7", {15'h0, irq_a}, {15'h0, m_fa});
                    check("R8", {15'h0, irq_b}, {15'h0, m_fb});
                end else begin
                    op_idle();
                end
            end
            op_idle();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule